// File: doc/BRIEF.md
# Register-Programmed SPI Master with Word FIFOs

This block is a bus-attached SPI master. Software programs a divider, a configuration word and an interrupt enable through a small 32-bit register window. It then writes words into a transmit queue. The shift engine takes one queued word at a time and clocks it out on the serial clock and data-out pins. On the same clock edges it samples the data-in pin, or its own data-out pin when internal loopback is selected, and stores the received word in a receive queue. Software pops that queue by reading the receive register.

Clock polarity, clock phase, bit order and word length (1 to 16 bits) are set in the configuration register. A configuration bit acts as a soft reset: it empties both queues and stops the shifter. Chip select is driven elsewhere. A level interrupt tells software when all queued transmit work has finished.

Back-pressure works by dropping, not by waiting. The bus never stalls. A write to a full transmit queue is lost, and a word that completes while the receive queue is full is lost. Internally the transmit queue feeds the shifter over a valid/ready pair. The shifter asserts ready only when it is idle and allowed to run, and a word moves only when valid and ready are both high in the same cycle.

Top module: `spi_fifo_master`

Register map (byte offsets; the register index is `reg_addr[4:2]`):

| Offset | Register | Access |
|---|---|---|
| 0x00 | divider, bits [15:0] | read/write |
| 0x04 | transmit word, bits [15:0] | write pushes one word; reads return 0 |
| 0x08 | receive word | read pops one word |
| 0x0C | configuration, bits [12:0] | read/write |
| 0x10 | interrupt enable, bit 2 | read/write |
| 0x18 | mode select, bit 0 | read/write |

## Requirements
- R1: After reset, the divider, configuration, interrupt enable, mode select and receive registers all read 0, and `sclk_o`, `mosi_o` and `irq_o` are low.
- R2: A divider value B gives B clock cycles between consecutive serial-clock edges within a word. A value of 0 counts as 65536.
- R3: Configuration bits [3:0] hold the word length minus one. Bits of the transmit word above that length are never sent. Received words are right-aligned in bits [15:0] and carry zeros above the word length.
- R4: Configuration bit 4 set sends and receives the most significant bit first. Clear, the least significant bit goes first.
- R5: Configuration bit 6 sets the idle level of `sclk_o`. Bit 5 clear samples on the leading edge of each bit period, with data set up before it. Bit 5 set drives data on the leading edge and samples on the trailing edge.
- R6: Configuration bit 10 set makes the receive path sample `mosi_o` instead of `miso_i`.
- R7: With configuration bit 11 set, the transmit queue holds 8 words. With bit 11 clear, it holds 1 word. Writes to a full queue are dropped.
- R8: With configuration bit 12 set, the receive queue holds 8 words. With bit 12 clear, it holds 1 word. Words that complete while the queue is full are discarded. Each read of offset 0x08 pops one word. A read of an empty queue returns 0.
- R9: While configuration bit 7 is 1, both queues are emptied, the shifter is idle, and nothing is transferred. Writing 0 releases the block.
- R10: A word starts only while configuration bit 9 (enable) is 1, configuration bit 8 (master) is 1 and mode-select bit 0 is 0.
- R11: `irq_o` is high exactly when interrupt-enable bit 2 is set, the transmit queue is empty and the shifter is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops the receive queue at 0x08) |
| reg_addr | input | 5 | Byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from the address |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| irq_o | output | 1 | Transfer-done interrupt, level |

## Verification
`reg_rdata` follows the address in the same cycle. The pop and the transmit push both take effect at the clock edge that ends the strobe. Once a word is queued and the block is allowed to run, the shifter takes it at the next edge, and the first serial-clock edge follows B cycles later. Within a word, edges come every B cycles. The receive push and the fall of the busy state land on the same edge, so `irq_o` rises in the very cycle the last word becomes readable.

The bench samples on the falling clock edge and times serial-clock edges with a cycle counter. It waits for `irq_o` before reading back, and it holds long enough to cover the 65536 case.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;
  localparam int WORD_W = 16;
  localparam int CODE_W = $clog2(WORD_W);
  localparam int BAUD_W = 16;
  localparam int CTL_W  = 13;

  // register indices (byte address bits [4:2])
  localparam logic [2:0] IX_BAUD = 3'd0;
  localparam logic [2:0] IX_TX   = 3'd1;
  localparam logic [2:0] IX_RX   = 3'd2;
  localparam logic [2:0] IX_CTL  = 3'd3;
  localparam logic [2:0] IX_IEN  = 3'd4;
  localparam logic [2:0] IX_MODE = 3'd6;

  // configuration bit positions
  localparam int B_MSB  = 4;
  localparam int B_CPHA = 5;
  localparam int B_CPOL = 6;
  localparam int B_SRST = 7;
  localparam int B_MAST = 8;
  localparam int B_EN   = 9;
  localparam int B_LOOP = 10;
  localparam int B_TXQ  = 11;
  localparam int B_RXQ  = 12;
  localparam int B_TEIE = 2;

  typedef struct packed {
    logic [CODE_W-1:0] wcode;
    logic              msb;
    logic              cpha;
    logic              cpol;
    logic              loop;
  } shift_cfg_t;
endpackage

// File: rtl/spi_word_fifo.sv
module spi_word_fifo #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             single,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic             empty,
  output logic             full,
  output logic [CW-1:0]    count
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic             do_push, do_pop;

  assign empty   = (count == '0);
  assign full    = single ? (count != '0) : (count == CW'(DEPTH));
  assign do_push = push & ~full;
  assign do_pop  = pop & ~empty;
  assign dout    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + AW'(1);
      if (do_pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + AW'(1);
      if (do_push && !do_pop)      count <= count + CW'(1);
      else if (do_pop && !do_push) count <= count - CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end
endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core
  import spi_fifo_pkg::*;
#(
  parameter int WMAX = WORD_W,
  parameter int BW   = BAUD_W,
  localparam int XW = $clog2(WMAX),
  localparam int IW = XW + 1,
  localparam int EW = IW + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hold,
  input  logic            go,
  input  shift_cfg_t      cfg,
  input  logic [BW-1:0]   baud,
  input  logic            tx_valid,
  output logic            tx_ready,
  input  logic [WMAX-1:0] tx_word,
  input  logic            miso,
  output logic            sclk,
  output logic            mosi,
  output logic            rx_valid,
  output logic [WMAX-1:0] rx_word,
  output logic            busy
);
  logic [BW-1:0]   cnt_q, baud_q;
  logic [EW-1:0]   edge_q;
  logic [IW-1:0]   kd_q, ks_q, wlen_q;
  logic            msb_q, cpha_q, loop_q;
  logic [WMAX-1:0] txw_q, rxw_q, rx_next;
  logic            tick, last, samp, drv, in_bit, start;

  function automatic logic [XW-1:0] bitpos(input logic m, input logic [IW-1:0] len,
                                           input logic [IW-1:0] k);
    logic [IW-1:0] t;
    t = m ? (len - k - IW'(1)) : k;
    return t[XW-1:0];
  endfunction

  assign tx_ready = ~busy & go & ~hold;
  assign start    = tx_ready & tx_valid;
  // a divider of 0 wraps to the all-ones limit: 65536 cycles
  assign tick     = busy & (cnt_q == (baud_q - BW'(1)));
  assign last     = (edge_q == ({wlen_q, 1'b0} - EW'(1)));
  // even edges are leading; phase decides which kind samples
  assign samp     = (edge_q[0] == cpha_q);
  assign drv      = ~samp & ~last;
  assign in_bit   = loop_q ? mosi : miso;

  always_comb begin
    rx_next = rxw_q;
    if (samp) rx_next[bitpos(msb_q, wlen_q, ks_q)] = in_bit;
  end

  assign rx_valid = tick & last;
  assign rx_word  = rx_next;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; cnt_q <= '0; baud_q <= '0; edge_q <= '0;
      kd_q <= '0; ks_q <= '0; wlen_q <= '0;
      msb_q <= 1'b0; cpha_q <= 1'b0; loop_q <= 1'b0;
      txw_q <= '0; rxw_q <= '0; sclk <= 1'b0; mosi <= 1'b0;
    end else if (hold) begin
      busy <= 1'b0;
      cnt_q <= '0;
      sclk <= cfg.cpol;
    end else if (start) begin
      busy   <= 1'b1;
      cnt_q  <= '0;
      baud_q <= baud;
      edge_q <= '0;
      wlen_q <= IW'(cfg.wcode) + IW'(1);
      msb_q  <= cfg.msb;
      cpha_q <= cfg.cpha;
      loop_q <= cfg.loop;
      txw_q  <= tx_word;
      rxw_q  <= '0;
      ks_q   <= '0;
      sclk   <= cfg.cpol;
      if (cfg.cpha) begin
        mosi <= 1'b0;
        kd_q <= '0;
      end else begin
        mosi <= tx_word[cfg.msb ? cfg.wcode : XW'(0)];
        kd_q <= IW'(1);
      end
    end else if (busy) begin
      if (tick) begin
        cnt_q  <= '0;
        sclk   <= ~sclk;
        edge_q <= edge_q + EW'(1);
        if (samp) begin
          rxw_q <= rx_next;
          ks_q  <= ks_q + IW'(1);
        end
        if (drv) begin
          mosi <= txw_q[bitpos(msb_q, wlen_q, kd_q)];
          kd_q <= kd_q + IW'(1);
        end
        if (last) busy <= 1'b0;
      end else begin
        cnt_q <= cnt_q + BW'(1);
      end
    end else begin
      sclk <= cfg.cpol;
    end
  end
endmodule

// File: rtl/spi_fifo_master.sv
module spi_fifo_master
  import spi_fifo_pkg::*;
#(
  parameter int FIFO_DEPTH = 8,
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [4:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        sclk_o,
  output logic        mosi_o,
  input  logic        miso_i,
  output logic        irq_o
);
  logic [BAUD_W-1:0] baud_q;
  logic [CTL_W-1:0]  ctl_q;
  logic              ien_q, mode_q;
  logic [2:0]        widx;
  logic              tx_push, rx_pop, srst, run_ok, cfg_cpol;
  logic              tx_empty, tx_full, tx_ready, tx_pop;
  logic              rx_empty, rx_full, rx_valid, eng_busy;
  logic [WORD_W-1:0] tx_head, rx_head, rx_word;
  logic [CNT_W-1:0]  tx_cnt, rx_cnt;
  shift_cfg_t        cfg;
  logic              unused_bits;

  assign unused_bits = ^{reg_addr[1:0], reg_wdata[31:16], tx_full, rx_full};
  assign widx     = reg_addr[4:2];
  assign tx_push  = reg_wr & (widx == IX_TX);
  assign rx_pop   = reg_rd & (widx == IX_RX);
  assign srst     = ctl_q[B_SRST];
  assign run_ok   = ctl_q[B_EN] & ctl_q[B_MAST] & ~mode_q;
  assign cfg_cpol = ctl_q[B_CPOL];
  assign tx_pop   = tx_ready & ~tx_empty;

  assign cfg.wcode = ctl_q[CODE_W-1:0];
  assign cfg.msb   = ctl_q[B_MSB];
  assign cfg.cpha  = ctl_q[B_CPHA];
  assign cfg.cpol  = ctl_q[B_CPOL];
  assign cfg.loop  = ctl_q[B_LOOP];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      baud_q <= '0;
      ctl_q  <= '0;
      ien_q  <= 1'b0;
      mode_q <= 1'b0;
    end else if (reg_wr) begin
      case (widx)
        IX_BAUD: baud_q <= reg_wdata[BAUD_W-1:0];
        IX_CTL:  ctl_q  <= reg_wdata[CTL_W-1:0];
        IX_IEN:  ien_q  <= reg_wdata[B_TEIE];
        IX_MODE: mode_q <= reg_wdata[0];
        default: ;
      endcase
    end
  end

  spi_word_fifo #(.WIDTH(WORD_W), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .flush(srst), .single(~ctl_q[B_TXQ]),
    .push(tx_push), .din(reg_wdata[WORD_W-1:0]), .pop(tx_pop),
    .dout(tx_head), .empty(tx_empty), .full(tx_full), .count(tx_cnt)
  );

  spi_word_fifo #(.WIDTH(WORD_W), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .flush(srst), .single(~ctl_q[B_RXQ]),
    .push(rx_valid), .din(rx_word), .pop(rx_pop),
    .dout(rx_head), .empty(rx_empty), .full(rx_full), .count(rx_cnt)
  );

  spi_shift_core #(.WMAX(WORD_W), .BW(BAUD_W)) u_core (
    .clk(clk), .rst_n(rst_n), .hold(srst), .go(run_ok), .cfg(cfg),
    .baud(baud_q), .tx_valid(~tx_empty), .tx_ready(tx_ready),
    .tx_word(tx_head), .miso(miso_i), .sclk(sclk_o), .mosi(mosi_o),
    .rx_valid(rx_valid), .rx_word(rx_word), .busy(eng_busy)
  );

  always_comb begin
    reg_rdata = '0;
    case (widx)
      IX_BAUD: reg_rdata[BAUD_W-1:0] = baud_q;
      IX_RX:   reg_rdata[WORD_W-1:0] = rx_empty ? '0 : rx_head;
      IX_CTL:  reg_rdata[CTL_W-1:0]  = ctl_q;
      IX_IEN:  reg_rdata[B_TEIE]     = ien_q;
      IX_MODE: reg_rdata[0]          = mode_q;
      default: ;
    endcase
  end

  assign irq_o = ien_q & tx_empty & ~eng_busy;
endmodule

// File: rtl/spi_fifo_master_chk.sv
module spi_fifo_master_chk #(
  parameter int DEPTH = 8,
  parameter int CW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic [CW-1:0] tx_cnt,
  input logic [CW-1:0] rx_cnt,
  input logic          srst,
  input logic          run_ok,
  input logic          irq,
  input logic          sclk,
  input logic          cpol
);
  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_cnt <= CW'(DEPTH));

  assert_rx_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_cnt <= CW'(DEPTH));

  assert_flush_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(srst) |-> (tx_cnt == '0) && (rx_cnt == '0) && !busy);

  assert_start_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(run_ok && !srst));

  assert_irq_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (tx_cnt == '0) && !busy);

  assert_idle_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!busy) |-> sclk == $past(cpol));
endmodule

bind spi_fifo_master spi_fifo_master_chk #(.DEPTH(FIFO_DEPTH), .CW(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(eng_busy), .tx_cnt(tx_cnt), .rx_cnt(rx_cnt),
  .srst(srst), .run_ok(run_ok), .irq(irq_o), .sclk(sclk_o), .cpol(cfg_cpol)
);

// File: tb/sim_spi_fifo_master.sv
module sim_spi_fifo_master;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        sclk_o, mosi_o, irq_o;
  logic        miso_r = 1'b0;

  int checks = 0, errs = 0;
  int cyc = 0, edges = 0, gap = 0, last_t = 0, cap_n = 0;
  bit cap [4096];
  logic sclk_prev = 1'b0;
  logic m_cpol = 1'b0, m_cpha = 1'b0;

  localparam logic [4:0] A_BAUD = 5'h00, A_TX = 5'h04, A_RX = 5'h08,
                         A_CTL = 5'h0C, A_IEN = 5'h10, A_MODE = 5'h18;

  spi_fifo_master u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .sclk_o(sclk_o), .mosi_o(mosi_o), .miso_i(miso_r), .irq_o(irq_o)
  );

  always #10 clk = ~clk;

  // serial monitor and watchdog, sampled away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (sclk_o !== sclk_prev) begin
      edges++;
      gap = cyc - last_t;
      last_t = cyc;
      if ((sclk_prev == m_cpol) != m_cpha) begin
        cap[cap_n % 4096] = mosi_o;
        cap_n++;
      end
    end
    sclk_prev = sclk_o;
    if (cyc > 190000) begin
      errs++;
      $display("FAIL watchdog: actual=%0d cycles expected=<190000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errs);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_irq();
    while (irq_o !== 1'b1) @(negedge clk);
  endtask

  function automatic logic [31:0] cfgword(input int cpol, cpha, msb, code, loop,
                                          input bit en);
    return 32'(code) | (32'(msb) << 4) | (32'(cpha) << 5) | (32'(cpol) << 6) |
           (32'd1 << 8) | (32'(en) << 9) | (32'(loop) << 10) | (32'd3 << 11);
  endfunction

  function automatic logic [15:0] wmask(input int code);
    return 16'((32'd1 << (code + 1)) - 1);
  endfunction

  task automatic batch(input int cpol, cpha, msb, code, baud, loop, n,
                       input logic mv);
    logic [15:0] w [8];
    logic [31:0] d;
    int base, bad, wl;
    wl = code + 1;
    wr(A_CTL, cfgword(cpol, cpha, msb, code, loop, 0));
    wr(A_BAUD, 32'(baud));
    m_cpol = cpol[0]; m_cpha = cpha[0]; miso_r = mv;
    idle(3);
    base = cap_n;
    for (int i = 0; i < n; i++) begin
      w[i] = 16'($urandom);
      wr(A_TX, {16'h0, w[i]});
    end
    wr(A_CTL, cfgword(cpol, cpha, msb, code, loop, 1));
    wait_irq();
    idle(1);
    chk(cap_n - base == n * wl, "R5 sampled bit count", 32'(cap_n - base), 32'(n * wl));
    chk(gap == baud, "R2 edge spacing", 32'(gap), 32'(baud));
    chk(sclk_o == cpol[0], "R5 idle level", 32'(sclk_o), 32'(cpol));
    bad = 0;
    for (int i = 0; i < n; i++)
      for (int k = 0; k < wl; k++)
        if (cap[(base + i * wl + k) % 4096] != (msb != 0 ? w[i][wl-1-k] : w[i][k])) bad++;
    chk(bad == 0, "R4 bit order on mosi", 32'(bad), 32'd0);
    for (int i = 0; i < n; i++) begin
      rd(A_RX, d);
      if (loop != 0) chk(d == {16'h0, w[i] & wmask(code)}, "R3 R6 loopback word", d,
                         {16'h0, w[i] & wmask(code)});
      else chk(d == {16'h0, mv ? wmask(code) : 16'h0}, "R6 external input word", d,
               {16'h0, mv ? wmask(code) : 16'h0});
    end
    rd(A_RX, d);
    chk(d == 0, "R8 empty read", d, 0);
  endtask

  initial begin
    logic [31:0] d;
    int e0;
    void'($urandom(32'h1234abcd));
    idle(4);
    rst_n = 1'b1;
    idle(2);
    // R1 reset state
    rd(A_BAUD, d); chk(d == 0, "R1 divider reset", d, 0);
    rd(A_CTL, d);  chk(d == 0, "R1 config reset", d, 0);
    rd(A_IEN, d);  chk(d == 0, "R1 irq enable reset", d, 0);
    rd(A_MODE, d); chk(d == 0, "R1 mode reset", d, 0);
    rd(A_RX, d);   chk(d == 0, "R1 receive reset", d, 0);
    chk({sclk_o, mosi_o, irq_o} == 3'b000, "R1 pins low", 32'({sclk_o, mosi_o, irq_o}), 0);

    // R11 interrupt follows enable while idle
    wr(A_IEN, 32'h4);
    #1 chk(irq_o == 1'b1, "R11 irq when idle and enabled", 32'(irq_o), 1);

    // R10 gating by enable, master bit and mode select
    wr(A_BAUD, 7);
    wr(A_CTL, cfgword(0, 0, 1, 7, 1, 1) & ~32'h100);
    e0 = edges;
    wr(A_TX, 32'hA5);
    idle(200);
    chk(irq_o == 1'b0 && edges == e0, "R10 no start without master", 32'(edges - e0), 0);
    wr(A_MODE, 1);
    wr(A_CTL, cfgword(0, 0, 1, 7, 1, 1));
    idle(200);
    chk(irq_o == 1'b0 && edges == e0, "R10 no start with mode select set", 32'(edges - e0), 0);
    wr(A_MODE, 0);
    wait_irq();
    rd(A_RX, d); chk(d == 32'hA5, "R10 word sent once released", d, 32'hA5);

    // R7 transmit overflow: 10 writes, 8 kept
    wr(A_CTL, cfgword(0, 0, 1, 7, 1, 0));
    for (int i = 0; i < 10; i++) wr(A_TX, 32'(8'h11 * (i + 1)));
    wr(A_CTL, cfgword(0, 0, 1, 7, 1, 1));
    wait_irq();
    for (int i = 0; i < 8; i++) begin
      rd(A_RX, d); chk(d == 32'(8'h11 * (i + 1)), "R7 kept word", d, 32'(8'h11 * (i + 1)));
    end
    rd(A_RX, d); chk(d == 0, "R7 extra writes dropped", d, 0);

    // R8 receive overflow: 10 words received, first 8 kept
    for (int i = 0; i < 8; i++) wr(A_TX, 32'(8'h21 + i));
    wait_irq();
    wr(A_TX, 32'h77); wr(A_TX, 32'h78);
    wait_irq();
    for (int i = 0; i < 8; i++) begin
      rd(A_RX, d); chk(d == 32'(8'h21 + i), "R8 kept word", d, 32'(8'h21 + i));
    end
    rd(A_RX, d); chk(d == 0, "R8 words beyond full discarded", d, 0);

    // R7 R8 single-entry queues when bits 11/12 clear
    wr(A_CTL, cfgword(0, 0, 1, 7, 1, 0) & ~32'h1800);
    wr(A_TX, 32'h31); wr(A_TX, 32'h32); wr(A_TX, 32'h33);
    wr(A_CTL, cfgword(0, 0, 1, 7, 1, 1) & ~32'h1800);
    wait_irq();
    wr(A_TX, 32'h34);
    wait_irq();
    rd(A_RX, d); chk(d == 32'h31, "R8 single receive entry", d, 32'h31);
    rd(A_RX, d); chk(d == 0, "R7 single transmit entry", d, 0);

    // R9 soft reset flushes queued work
    wr(A_CTL, cfgword(0, 0, 1, 7, 1, 0));
    wr(A_TX, 32'h41); wr(A_TX, 32'h42);
    wr(A_CTL, cfgword(0, 0, 1, 7, 1, 0) | 32'h80);
    wr(A_CTL, cfgword(0, 0, 1, 7, 1, 1));
    e0 = edges;
    idle(100);
    chk(irq_o == 1'b1 && edges == e0, "R9 nothing sent after flush", 32'(edges - e0), 0);
    rd(A_RX, d); chk(d == 0, "R9 receive empty after flush", d, 0);

    // directed mode corners
    batch(0, 0, 1, 15, 9, 1, 4, 1'b0);
    batch(1, 1, 0, 1, 7, 1, 3, 1'b0);
    batch(1, 0, 0, 4, 8, 0, 2, 1'b1);
    batch(0, 1, 1, 11, 7, 0, 2, 1'b0);
    // random configurations
    for (int t = 0; t < 6; t++)
      batch($urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 1),
            $urandom_range(1, 15), $urandom_range(7, 9), 1, $urandom_range(1, 8), 1'b0);

    // R2 divider of 0 means 65536, then abort with soft reset (R9)
    wr(A_CTL, cfgword(0, 0, 1, 15, 1, 0));
    wr(A_BAUD, 0);
    m_cpol = 1'b0; m_cpha = 1'b0;
    idle(2);
    wr(A_TX, 32'hBEEF);
    e0 = edges;
    wr(A_CTL, cfgword(0, 0, 1, 15, 1, 1));
    while (edges < e0 + 2) @(negedge clk);
    chk(gap == 65536, "R2 zero divider", 32'(gap), 32'd65536);
    wr(A_CTL, cfgword(0, 0, 1, 15, 1, 1) | 32'h80);
    idle(2);
    chk(irq_o == 1'b1 && sclk_o == 1'b0, "R9 shifter stopped", 32'({irq_o, sclk_o}), 32'h2);
    wr(A_CTL, cfgword(0, 0, 1, 15, 1, 1));
    rd(A_RX, d); chk(d == 0, "R9 aborted word not stored", d, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  end
endmodule